// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block carries out the processor-side steps of taking and leaving an interrupt. When an entry request arrives together with an 8-bit interrupt number, it saves the flags word and the current code segment and instruction pointer on a 16-bit descending stack. It then masks further interrupts and single-stepping, and loads a new code segment and instruction pointer from a 4-byte slot in the vector table at the bottom of memory. A separate return request pops the instruction pointer, the code segment and the flags word, in that order. Restoring the flags is what separates this from a plain far return.

All memory traffic goes through one word-wide port with a request/acknowledge handshake. A physical byte address is formed as segment × 16 + offset, modulo 2^20. The architectural flags, CS, IP and SP registers are visible as outputs. Their reset values are parameters. The stack segment comes in from outside.

The controller has these states: IDLE, PUSH_FL, PUSH_CS, PUSH_IP, VEC_IP, VEC_CS, POP_IP, POP_CS, POP_FL and DONE. The transitions are:
- IDLE goes to PUSH_FL on an entry request, or to POP_IP on a return request alone.
- Each access state advances on an acknowledge. The order is PUSH_FL→PUSH_CS→PUSH_IP→VEC_IP→VEC_CS→DONE for entry, and POP_IP→POP_CS→POP_FL→DONE for return.
- DONE goes back to IDLE unconditionally.

Top module: `irq_seq_top`

## Requirements
- R1: After reset, busy, done and mem_req are low, and flags_o, cs_o, ip_o and sp_o hold their reset parameter values.
- R2: Entry performs three word writes: the flags word at stack_seg:SP−2, then CS at SP−4, then IP at SP−6. SP is reduced by 2 as each write is acknowledged.
- R3: The flags image written to the stack is the value from before entry. After that write is acknowledged, bit 9 (interrupt enable) and bit 8 (trap) are cleared, and all other flag bits are kept.
- R4: After the pushes, the vector for number n is read from segment 0: the IP word at offset 4n, then the CS word at offset 4n+2. The words read are loaded into ip_o and cs_o.
- R5: Return performs three word reads at stack_seg:SP, SP+2 and SP+4. They load IP, CS and flags in that order, and SP ends 6 higher.
- R6: While an access waits for mem_ack, mem_req, mem_we and mem_addr stay steady and SP does not change.
- R7: busy rises on the cycle after an accepted request and stays high through a single-cycle done pulse that ends the sequence. busy and done are low on the following cycle.
- R8: Entry or return requests that arrive while busy have no effect, including a changed vector number.
- R9: When entry and return are requested in the same idle cycle, the entry sequence runs.
- R10: Physical addresses are segment×16+offset modulo 2^20, and SP arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_req | input | 1 | Start an interrupt entry |
| vec_num | input | 8 | Interrupt number, sampled with enter_req |
| ret_req | input | 1 | Start an interrupt return |
| stack_seg | input | 16 | Stack segment |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| flags_o | output | 16 | Flags register |
| cs_o | output | 16 | Code segment |
| ip_o | output | 16 | Instruction pointer |
| sp_o | output | 16 | Stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong state in the controller shows up on the memory port at the very next access: a misplaced address, a wrong write/read direction, or an access that is missing or extra. The bench logs every acknowledged access and compares it against the expected ordering. A corrupted SP or flags value appears in the register outputs on the done cycle, and later in the addresses of the following sequence. Every one of the 256 vector numbers is swept with varied acknowledge latency and stack segments, so a slip in vector address arithmetic is caught within that entry's two table reads.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    localparam int WORD_W    = 16;
    localparam int SEG_SHIFT = 4;
    localparam int ADDR_W    = WORD_W + SEG_SHIFT;
    localparam int VEC_W     = 8;
    localparam int VEC_SHIFT = 2;
    localparam int FL_IF     = 9;
    localparam int FL_TF     = 8;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] paddr_t;

    localparam word_t STEP = word_t'(2);

    typedef enum logic [3:0] {
        S_IDLE, S_PUSH_FL, S_PUSH_CS, S_PUSH_IP, S_VEC_IP,
        S_VEC_CS, S_POP_IP, S_POP_CS, S_POP_FL, S_DONE
    } seq_state_t;

    function automatic paddr_t to_phys(input word_t seg, input word_t off);
        return {seg, {SEG_SHIFT{1'b0}}} + paddr_t'(off);
    endfunction
endpackage

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enter_req,
    input  logic       ret_req,
    input  logic       mem_ack,
    output seq_state_t state,
    output logic       busy,
    output logic       done,
    output logic       mem_req,
    output logic       mem_we
);
    seq_state_t nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (enter_req)    nxt = S_PUSH_FL;
                else if (ret_req) nxt = S_POP_IP;
            end
            S_PUSH_FL: if (mem_ack) nxt = S_PUSH_CS;
            S_PUSH_CS: if (mem_ack) nxt = S_PUSH_IP;
            S_PUSH_IP: if (mem_ack) nxt = S_VEC_IP;
            S_VEC_IP:  if (mem_ack) nxt = S_VEC_CS;
            S_VEC_CS:  if (mem_ack) nxt = S_DONE;
            S_POP_IP:  if (mem_ack) nxt = S_POP_CS;
            S_POP_CS:  if (mem_ack) nxt = S_POP_FL;
            S_POP_FL:  if (mem_ack) nxt = S_DONE;
            S_DONE:    nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    always_comb begin
        busy    = 1'b1;
        done    = 1'b0;
        mem_req = 1'b0;
        mem_we  = 1'b0;
        unique case (state)
            S_IDLE:                        busy = 1'b0;
            S_PUSH_FL, S_PUSH_CS, S_PUSH_IP: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            S_VEC_IP, S_VEC_CS,
            S_POP_IP, S_POP_CS, S_POP_FL:  mem_req = 1'b1;
            S_DONE:                        done = 1'b1;
            default:                       busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_seq_regs.sv
module irq_seq_regs
    import irq_seq_pkg::*;
#(
    parameter word_t RST_FLAGS = 16'h0202,
    parameter word_t RST_CS    = 16'hF000,
    parameter word_t RST_IP    = 16'hFFF0,
    parameter word_t RST_SP    = 16'hFFFE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_state_t       state,
    input  logic             enter_req,
    input  logic [VEC_W-1:0] vec_in,
    input  logic             mem_ack,
    input  word_t            mem_rdata,
    output word_t            flags,
    output word_t            cs,
    output word_t            ip,
    output word_t            sp,
    output logic [VEC_W-1:0] vnum
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= RST_FLAGS;
            cs    <= RST_CS;
            ip    <= RST_IP;
            sp    <= RST_SP;
            vnum  <= '0;
        end else begin
            if (state == S_IDLE && enter_req) vnum <= vec_in;
            if (mem_ack) begin
                unique case (state)
                    S_PUSH_FL: begin
                        sp           <= sp - STEP;
                        flags[FL_IF] <= 1'b0;
                        flags[FL_TF] <= 1'b0;
                    end
                    S_PUSH_CS, S_PUSH_IP: sp <= sp - STEP;
                    S_VEC_IP: ip <= mem_rdata;
                    S_VEC_CS: cs <= mem_rdata;
                    S_POP_IP: begin ip <= mem_rdata;    sp <= sp + STEP; end
                    S_POP_CS: begin cs <= mem_rdata;    sp <= sp + STEP; end
                    S_POP_FL: begin flags <= mem_rdata; sp <= sp + STEP; end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/irq_seq_agen.sv
module irq_seq_agen
    import irq_seq_pkg::*;
(
    input  seq_state_t       state,
    input  word_t            ss,
    input  word_t            sp,
    input  word_t            flags,
    input  word_t            cs,
    input  word_t            ip,
    input  logic [VEC_W-1:0] vnum,
    output paddr_t           addr,
    output word_t            wdata
);
    word_t seg, off, vec_base;

    assign vec_base = word_t'({vnum, {VEC_SHIFT{1'b0}}});

    always_comb begin
        seg   = '0;
        off   = '0;
        wdata = '0;
        unique case (state)
            S_PUSH_FL: begin seg = ss; off = sp - STEP; wdata = flags; end
            S_PUSH_CS: begin seg = ss; off = sp - STEP; wdata = cs;    end
            S_PUSH_IP: begin seg = ss; off = sp - STEP; wdata = ip;    end
            S_VEC_IP:  off = vec_base;
            S_VEC_CS:  off = vec_base + STEP;
            S_POP_IP, S_POP_CS, S_POP_FL: begin seg = ss; off = sp; end
            default: ;
        endcase
        addr = to_phys(seg, off);
    end
endmodule

// File: rtl/irq_seq_top.sv
module irq_seq_top
    import irq_seq_pkg::*;
#(
    parameter logic [WORD_W-1:0] RST_FLAGS = 16'h0202,
    parameter logic [WORD_W-1:0] RST_CS    = 16'hF000,
    parameter logic [WORD_W-1:0] RST_IP    = 16'hFFF0,
    parameter logic [WORD_W-1:0] RST_SP    = 16'hFFFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_req,
    input  logic [VEC_W-1:0]  vec_num,
    input  logic              ret_req,
    input  logic [WORD_W-1:0] stack_seg,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [WORD_W-1:0] flags_o,
    output logic [WORD_W-1:0] cs_o,
    output logic [WORD_W-1:0] ip_o,
    output logic [WORD_W-1:0] sp_o,
    output logic              busy,
    output logic              done
);
    seq_state_t       state;
    logic [VEC_W-1:0] vnum;

    irq_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .ret_req(ret_req),
        .mem_ack(mem_ack), .state(state), .busy(busy), .done(done),
        .mem_req(mem_req), .mem_we(mem_we)
    );

    irq_seq_regs #(
        .RST_FLAGS(RST_FLAGS), .RST_CS(RST_CS), .RST_IP(RST_IP), .RST_SP(RST_SP)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .state(state), .enter_req(enter_req),
        .vec_in(vec_num), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .flags(flags_o), .cs(cs_o), .ip(ip_o), .sp(sp_o), .vnum(vnum)
    );

    irq_seq_agen u_agen (
        .state(state), .ss(stack_seg), .sp(sp_o), .flags(flags_o),
        .cs(cs_o), .ip(ip_o), .vnum(vnum), .addr(mem_addr), .wdata(mem_wdata)
    );
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        enter_req,
    input logic        busy,
    input logic        done,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [19:0] mem_addr,
    input logic [15:0] sp_o
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                            // R7
    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);                                             // R7
    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);                                  // R7
    AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);                                        // R1
    AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(sp_o))); // R6
    AST_PUSH_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (sp_o == $past(sp_o) - 16'd2)); // R2
    AST_ENTRY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && enter_req) |=> (busy && mem_req && mem_we));      // R9
endmodule

bind irq_seq_top irq_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .sp_o(sp_o)
);

// File: tb/irq_seq_top_tb.sv
`timescale 1ns/1ps
module irq_seq_top_tb;
    localparam logic [15:0] P_FLAGS = 16'h0BD5;
    localparam logic [15:0] P_CS    = 16'hF000;
    localparam logic [15:0] P_IP    = 16'hFFF0;
    localparam logic [15:0] P_SP    = 16'h0004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enter_req = 1'b0, ret_req = 1'b0;
    logic [7:0]  vec_num = '0;
    logic [15:0] stack_seg = '0;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata = '0;
    logic [15:0] flags_o, cs_o, ip_o, sp_o;
    logic        busy, done;

    int nchk = 0, nfail = 0;
    int lat = 0, wcnt = 0, nlog = 0;
    logic [19:0] lg_addr [0:7];
    logic        lg_we   [0:7];
    logic [15:0] lg_data [0:7];
    logic [19:0] hold_addr;
    logic [15:0] hold_sp;
    logic [15:0] e_fl, e_cs, e_ip, e_sp;

    always #2 clk = ~clk;

    irq_seq_top #(.RST_FLAGS(P_FLAGS), .RST_CS(P_CS), .RST_IP(P_IP), .RST_SP(P_SP)) u_dut (
        .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .vec_num(vec_num),
        .ret_req(ret_req), .stack_seg(stack_seg), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .flags_o(flags_o), .cs_o(cs_o), .ip_o(ip_o), .sp_o(sp_o),
        .busy(busy), .done(done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [19:0] bphys(input logic [15:0] s, input logic [15:0] o);
        int v;
        v = int'(s) * 16 + int'(o);
        return v[19:0];
    endfunction

    function automatic logic [15:0] mdata(input logic [19:0] a);
        return a[15:0] ^ {a[19:16], 12'h000} ^ 16'h5A3C;
    endfunction

    // memory model: variable latency, logs every acknowledged access
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0; wcnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0; wcnt = 0;
        end else if (mem_req) begin
            if (wcnt == 0) begin
                hold_addr = mem_addr; hold_sp = sp_o;
            end else begin
                chk("R6 addr held", mem_addr, hold_addr);
                chk("R6 sp held", sp_o, hold_sp);
            end
            if (wcnt >= lat) begin
                mem_ack = 1'b1;
                mem_rdata = mdata(mem_addr);
                if (nlog < 8) begin
                    lg_addr[nlog] = mem_addr; lg_we[nlog] = mem_we; lg_data[nlog] = mem_wdata;
                end
                nlog++;
                wcnt = 0;
            end else wcnt++;
        end
    end

    task automatic do_entry(input logic [7:0] n, input logic [15:0] ssv, input int lt, input bit both);
        logic [19:0] va;
        @(negedge clk);
        stack_seg = ssv; lat = lt; nlog = 0;
        enter_req = 1'b1; ret_req = both; vec_num = n;
        @(negedge clk);
        enter_req = 1'b0; ret_req = 1'b0;
        chk("R7 busy after start", busy, 1);
        for (int k = 0; k < 300; k++) begin
            if (done) break;
            chk("R7 busy held", busy, 1);
            if (k == 2) begin enter_req = 1'b1; ret_req = 1'b1; vec_num = ~n; end
            if (k == 3) begin enter_req = 1'b0; ret_req = 1'b0; end
            @(negedge clk);
        end
        chk("R7 done", done, 1);
        chk("R8/R9 access count", nlog, 5);
        chk("R2 push fl we", lg_we[0], 1);
        chk("R2/R10 push fl addr", lg_addr[0], bphys(ssv, e_sp - 16'd2));
        chk("R3 pushed flags image", lg_data[0], e_fl);
        chk("R2 push cs we", lg_we[1], 1);
        chk("R2/R10 push cs addr", lg_addr[1], bphys(ssv, e_sp - 16'd4));
        chk("R2 push cs data", lg_data[1], e_cs);
        chk("R2 push ip we", lg_we[2], 1);
        chk("R2/R10 push ip addr", lg_addr[2], bphys(ssv, e_sp - 16'd6));
        chk("R2 push ip data", lg_data[2], e_ip);
        va = 20'(int'(n) * 4);
        chk("R4 vec ip read", lg_we[3], 0);
        chk("R4/R8 vec ip addr", lg_addr[3], va);
        chk("R4 vec cs read", lg_we[4], 0);
        chk("R4/R8 vec cs addr", lg_addr[4], va + 20'd2);
        e_fl = e_fl & ~16'h0300;
        e_ip = mdata(va);
        e_cs = mdata(va + 20'd2);
        e_sp = e_sp - 16'd6;
        chk("R3 flags after entry", flags_o, e_fl);
        chk("R4 ip loaded", ip_o, e_ip);
        chk("R4 cs loaded", cs_o, e_cs);
        chk("R2/R10 sp after entry", sp_o, e_sp);
        @(negedge clk);
        chk("R7 done low after", done, 0);
        chk("R7 busy low after", busy, 0);
    endtask

    task automatic do_ret(input logic [15:0] ssv, input int lt);
        logic [19:0] a0, a1, a2;
        @(negedge clk);
        stack_seg = ssv; lat = lt; nlog = 0; ret_req = 1'b1;
        @(negedge clk);
        ret_req = 1'b0;
        chk("R7 busy after ret", busy, 1);
        for (int k = 0; k < 300; k++) begin
            if (done) break;
            @(negedge clk);
        end
        chk("R7 ret done", done, 1);
        chk("R5 access count", nlog, 3);
        a0 = bphys(ssv, e_sp);
        a1 = bphys(ssv, e_sp + 16'd2);
        a2 = bphys(ssv, e_sp + 16'd4);
        chk("R5 pop ip read", lg_we[0], 0);
        chk("R5/R10 pop ip addr", lg_addr[0], a0);
        chk("R5 pop cs read", lg_we[1], 0);
        chk("R5/R10 pop cs addr", lg_addr[1], a1);
        chk("R5 pop fl read", lg_we[2], 0);
        chk("R5/R10 pop fl addr", lg_addr[2], a2);
        e_ip = mdata(a0); e_cs = mdata(a1); e_fl = mdata(a2); e_sp = e_sp + 16'd6;
        chk("R5 ip restored", ip_o, e_ip);
        chk("R5 cs restored", cs_o, e_cs);
        chk("R5 flags restored", flags_o, e_fl);
        chk("R5 sp after ret", sp_o, e_sp);
        @(negedge clk);
        chk("R7 ret idle after", busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 mem_req", mem_req, 0);
        chk("R1 flags", flags_o, P_FLAGS);
        chk("R1 cs", cs_o, P_CS);
        chk("R1 ip", ip_o, P_IP);
        chk("R1 sp", sp_o, P_SP);
        e_fl = P_FLAGS; e_cs = P_CS; e_ip = P_IP; e_sp = P_SP;
        for (int n = 0; n < 256; n++) begin
            logic [15:0] ssv;
            ssv = (n % 16 == 15) ? 16'hFFFF : 16'h2000 + 16'(n * 16);
            do_entry(8'(n), ssv, n % 4, n == 0);
            do_ret(ssv, (n + 1) % 4);
        end
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule